// File: doc/BRIEF.md
# Streaming Control Register Access Permission Checker

This block decides, in one combinational evaluation, what happens when software issues a system-register move (read or write) that targets one of a pair of streaming-vector control registers: an upper copy owned by exception level 2 and a lower copy owned by exception level 1. From the current exception level, the selected register and a set of enable and virtualization controls, it returns exactly one outcome. The outcome is undefined-instruction, a trap (with its target level and exception class), access to the upper register, access to the lower register, or a redirect of the access to a fixed memory offset used by nested virtualization.

The checks form a strict priority chain. At level 2 and level 1 the chain runs from a level-3 early-undefined option, through the level-1 and level-2 enables, to the level-3 enable. When level-2 host mode is active, a lower-register access made at level 2 is steered onto the upper register. The register storage and the data path for the moved value live outside this block: it only produces the decision and a write-direction strobe.

Top module: `sysreg_perm_top`

## Requirements
- R1: Any access with curEl = 0 gives outcome UNDEF (code 0), whichever register is selected.
- R2: At curEl = 1 with regSel = 0 (upper register), nvBits[0] = 1 gives TRAP (code 1) to level 2 with class 0x18. Otherwise the outcome is UNDEF.
- R3: At curEl = 2 the checks run in this order, and the first that applies decides the outcome. (a) UNDEF when level 3 is present, sddUndefPrio = 1 and el3Enable = 0. (b) TRAP to level 2, class 0x1D, when hostMode = 0 and trapStream = 1. (c) TRAP to level 2, class 0x1D, when hostMode = 1 and el2EnLow = 0. (d) When level 3 is present and el3Enable = 0: UNDEF if sddUndef = 1, otherwise TRAP to level 3 with class 0x1D. If none applies, the selected register is accessed.
- R4: At curEl = 3 with level 3 present, el3Enable = 0 gives TRAP to level 3 with class 0x1D. Otherwise the selected register is accessed: ACC_UPPER (code 2) for regSel = 0, ACC_LOWER (code 3) for regSel = 1.
- R5: At curEl = 1 with regSel = 1, the checks run in this order. The early-undefined check from R3(a) comes first. Next, el1EnLow = 0 gives TRAP to level 1 with class 0x1D. Next, the R3(b) check applies, but only when el2Enabled = 1. Then the R3(c) check, then the R3(d) check.
- R6: At curEl = 1 with regSel = 1, once every check of R5 passes, nvBits = 3'b111 gives MEM_REDIRECT (code 4) with memOffset = 0x1F0. Any other nvBits value gives ACC_LOWER.
- R7: At curEl = 2 with regSel = 1, a permitted access goes to the upper register (ACC_UPPER) when hostMode = 1 and to the lower register (ACC_LOWER) when hostMode = 0.
- R8: isWrite has no effect on outcome, trapEl, trapClass or memOffset. xferWrite equals isWrite when the outcome is an access or a redirect, and is 0 otherwise.
- R9: trapEl and trapClass are 0 unless the outcome is TRAP. memOffset is 0 unless the outcome is MEM_REDIRECT.
- R10: With haveEl3 = 0, every level-3 check (R3(a), R3(d), and the same checks inside R5) is skipped, and any access at curEl = 3 is UNDEF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| curEl | input | 2 | Current exception level, 0 to 3 |
| regSel | input | 1 | 0 = upper (level-2) register, 1 = lower (level-1) register |
| isWrite | input | 1 | 1 = move to register, 0 = move from register |
| haveEl3 | input | 1 | Level 3 is implemented |
| el3Enable | input | 1 | Level-3 enable for streaming control access |
| trapStream | input | 1 | Level-2 trap bit used outside host mode |
| hostMode | input | 1 | Level 2 runs in host mode |
| el2Enabled | input | 1 | Level 2 is enabled in the current security state |
| el1EnLow | input | 1 | Low bit of the level-1 enable field |
| el2EnLow | input | 1 | Low bit of the level-2 enable field, used in host mode |
| nvBits | input | 3 | Nested-virtualization control bits |
| sddUndefPrio | input | 1 | Level-3 disable raises undefined at top priority |
| sddUndef | input | 1 | Level-3 disable raises undefined instead of a trap |
| outcome | output | 3 | 0 UNDEF, 1 TRAP, 2 ACC_UPPER, 3 ACC_LOWER, 4 MEM_REDIRECT |
| trapEl | output | 2 | Target level of a trap |
| trapClass | output | 6 | Exception class of a trap |
| memOffset | output | 12 | Redirect offset, 0x1F0 on a redirect |
| xferWrite | output | 1 | Write strobe for a permitted transfer |

## Verification
Every result is combinational, so each output is due in the same time step as the stimulus, with no clock edge in between. The bench drives each input vector, waits one nanosecond so that the combinational logic can settle, and samples before it changes anything else. A full sweep over every input combination compares all five outputs against a priority model written in the bench. Each check is tagged with the rule that decided the expected outcome.

// File: rtl/sysreg_perm_pkg.sv
package sysreg_perm_pkg;

  typedef enum logic [2:0] {
    OUT_UNDEF     = 3'd0,
    OUT_TRAP      = 3'd1,
    OUT_ACC_UPPER = 3'd2,
    OUT_ACC_LOWER = 3'd3,
    OUT_MEM       = 3'd4
  } outcome_e;

  // Internal decision of the cascade, before it is encoded.
  typedef enum logic [2:0] {
    DEC_UNDEF,
    DEC_TRAP_L1,
    DEC_TRAP_L2,
    DEC_TRAP_L2_SYS,
    DEC_TRAP_L3,
    DEC_UPPER,
    DEC_LOWER,
    DEC_MEM
  } decision_e;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic       doUndef;
    logic       doTrap;
    logic [1:0] trapLvl;
    logic       trapSys;
    logic       grantUpper;
    logic       grantLower;
    logic       grantMem;
  } perm_strobe_t;

endpackage

// File: rtl/sysreg_perm_ctrl.sv
module sysreg_perm_ctrl
  import sysreg_perm_pkg::*;
#(
  parameter int EL_W = 2,
  parameter int NV_W = 3
) (
  input  logic [EL_W-1:0] curEl,
  input  logic            regSel,
  input  logic            haveEl3,
  input  logic            el3Enable,
  input  logic            trapStream,
  input  logic            hostMode,
  input  logic            el2Enabled,
  input  logic            el1EnLow,
  input  logic            el2EnLow,
  input  logic [NV_W-1:0] nvBits,
  input  logic            sddUndefPrio,
  input  logic            sddUndef,
  output perm_strobe_t    strobes
);

  localparam logic [NV_W-1:0] NV_ALL = {NV_W{1'b1}};

  logic      el3Blocks;
  logic      earlyUndef;
  logic      hostTrap;
  logic      nonHostTrap;
  decision_e decision;

  assign el3Blocks   = haveEl3 & ~el3Enable;
  assign earlyUndef  = el3Blocks & sddUndefPrio;
  assign nonHostTrap = ~hostMode & trapStream;
  assign hostTrap    = hostMode & ~el2EnLow;

  always_comb begin
    decision = DEC_UNDEF;
    unique case (curEl)
      2'd0: decision = DEC_UNDEF;
      2'd1: begin
        if (!regSel) begin
          decision = nvBits[0] ? DEC_TRAP_L2_SYS : DEC_UNDEF;
        end else if (earlyUndef) begin
          decision = DEC_UNDEF;
        end else if (!el1EnLow) begin
          decision = DEC_TRAP_L1;
        end else if (el2Enabled && nonHostTrap) begin
          decision = DEC_TRAP_L2;
        end else if (hostTrap) begin
          decision = DEC_TRAP_L2;
        end else if (el3Blocks) begin
          decision = sddUndef ? DEC_UNDEF : DEC_TRAP_L3;
        end else if (nvBits == NV_ALL) begin
          decision = DEC_MEM;
        end else begin
          decision = DEC_LOWER;
        end
      end
      2'd2: begin
        if (earlyUndef) begin
          decision = DEC_UNDEF;
        end else if (nonHostTrap || hostTrap) begin
          decision = DEC_TRAP_L2;
        end else if (el3Blocks) begin
          decision = sddUndef ? DEC_UNDEF : DEC_TRAP_L3;
        end else if (!regSel || hostMode) begin
          decision = DEC_UPPER;
        end else begin
          decision = DEC_LOWER;
        end
      end
      default: begin
        if (!haveEl3) begin
          decision = DEC_UNDEF;
        end else if (!el3Enable) begin
          decision = DEC_TRAP_L3;
        end else begin
          decision = regSel ? DEC_LOWER : DEC_UPPER;
        end
      end
    endcase
  end

  always_comb begin
    strobes = '0;
    unique case (decision)
      DEC_UNDEF:       strobes.doUndef = 1'b1;
      DEC_TRAP_L1:     begin strobes.doTrap = 1'b1; strobes.trapLvl = 2'd1; end
      DEC_TRAP_L2:     begin strobes.doTrap = 1'b1; strobes.trapLvl = 2'd2; end
      DEC_TRAP_L2_SYS: begin strobes.doTrap = 1'b1; strobes.trapLvl = 2'd2; strobes.trapSys = 1'b1; end
      DEC_TRAP_L3:     begin strobes.doTrap = 1'b1; strobes.trapLvl = 2'd3; end
      DEC_UPPER:       strobes.grantUpper = 1'b1;
      DEC_LOWER:       strobes.grantLower = 1'b1;
      default:         strobes.grantMem = 1'b1;
    endcase
  end

  // R1: level 0 never reaches anything but undefined
  always_comb begin
    if (curEl == 2'd0) begin
      p_el0_undef_r1: assert (strobes.doUndef)
        else $error("level 0 access not undefined");
    end
  end

  // R10: without level 3 a level-3 trap must never be chosen
  always_comb begin
    if (!haveEl3) begin
      p_no_el3_trap_r10: assert (!(strobes.doTrap && strobes.trapLvl == 2'd3))
        else $error("level-3 trap without level 3");
    end
  end

endmodule

// File: rtl/sysreg_perm_dp.sv
module sysreg_perm_dp
  import sysreg_perm_pkg::*;
#(
  parameter int              EC_W    = 6,
  parameter int              OFF_W   = 12,
  parameter logic [EC_W-1:0] EC_SYS  = 6'h18,
  parameter logic [EC_W-1:0] EC_SVEC = 6'h1D,
  parameter logic [OFF_W-1:0] MEM_OFF = 12'h1F0
) (
  input  perm_strobe_t     strobes,
  input  logic             isWrite,
  output logic [2:0]       outcome,
  output logic [1:0]       trapEl,
  output logic [EC_W-1:0]  trapClass,
  output logic [OFF_W-1:0] memOffset,
  output logic             xferWrite
);

  logic granted;

  assign granted = strobes.grantUpper | strobes.grantLower | strobes.grantMem;

  always_comb begin
    if (strobes.doTrap)          outcome = OUT_TRAP;
    else if (strobes.grantUpper) outcome = OUT_ACC_UPPER;
    else if (strobes.grantLower) outcome = OUT_ACC_LOWER;
    else if (strobes.grantMem)   outcome = OUT_MEM;
    else                         outcome = OUT_UNDEF;
  end

  assign trapEl    = strobes.doTrap ? strobes.trapLvl : 2'd0;
  assign trapClass = !strobes.doTrap ? '0 : (strobes.trapSys ? EC_SYS : EC_SVEC);
  assign memOffset = strobes.grantMem ? MEM_OFF : '0;
  assign xferWrite = granted & isWrite;

  // R9: the control raises exactly one outcome strobe
  always_comb begin
    p_one_outcome_r9: assert ($onehot({strobes.doUndef, strobes.doTrap, strobes.grantUpper,
                                       strobes.grantLower, strobes.grantMem}))
      else $error("outcome strobes not one-hot");
  end

  // R9: a trap always carries a nonzero target level
  always_comb begin
    if (strobes.doTrap) begin
      p_trap_level_r9: assert (trapEl != 2'd0)
        else $error("trap without target level");
    end
  end

endmodule

// File: rtl/sysreg_perm_top.sv
module sysreg_perm_top
  import sysreg_perm_pkg::*;
#(
  parameter int EL_W  = 2,
  parameter int NV_W  = 3,
  parameter int EC_W  = 6,
  parameter int OFF_W = 12
) (
  input  logic [EL_W-1:0]  curEl,
  input  logic             regSel,
  input  logic             isWrite,
  input  logic             haveEl3,
  input  logic             el3Enable,
  input  logic             trapStream,
  input  logic             hostMode,
  input  logic             el2Enabled,
  input  logic             el1EnLow,
  input  logic             el2EnLow,
  input  logic [NV_W-1:0]  nvBits,
  input  logic             sddUndefPrio,
  input  logic             sddUndef,
  output logic [2:0]       outcome,
  output logic [1:0]       trapEl,
  output logic [EC_W-1:0]  trapClass,
  output logic [OFF_W-1:0] memOffset,
  output logic             xferWrite
);

  perm_strobe_t strobes;

  sysreg_perm_ctrl #(.EL_W(EL_W), .NV_W(NV_W)) ctrl_i (
    .curEl(curEl), .regSel(regSel), .haveEl3(haveEl3), .el3Enable(el3Enable),
    .trapStream(trapStream), .hostMode(hostMode), .el2Enabled(el2Enabled),
    .el1EnLow(el1EnLow), .el2EnLow(el2EnLow), .nvBits(nvBits),
    .sddUndefPrio(sddUndefPrio), .sddUndef(sddUndef), .strobes(strobes)
  );

  sysreg_perm_dp #(.EC_W(EC_W), .OFF_W(OFF_W)) dp_i (
    .strobes(strobes), .isWrite(isWrite), .outcome(outcome), .trapEl(trapEl),
    .trapClass(trapClass), .memOffset(memOffset), .xferWrite(xferWrite)
  );

  // R6: a memory redirect only arises from a level-1 lower access with all nv bits set
  always_comb begin
    if (outcome == OUT_MEM) begin
      p_mem_source_r6: assert (curEl == 2'd1 && regSel && (&nvBits))
        else $error("redirect from wrong source");
    end
  end

  // R8: the write strobe never appears without a write request
  always_comb begin
    if (xferWrite) begin
      p_write_dir_r8: assert (isWrite)
        else $error("write strobe on a read");
    end
  end

endmodule

// File: tb/sysreg_perm_tb.sv
module sysreg_perm_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0]  curEl;
  logic        regSel, isWrite, haveEl3, el3Enable, trapStream, hostMode, el2Enabled;
  logic        el1EnLow, el2EnLow, sddUndefPrio, sddUndef;
  logic [2:0]  nvBits;
  logic [2:0]  outcome;
  logic [1:0]  trapEl;
  logic [5:0]  trapClass;
  logic [11:0] memOffset;
  logic        xferWrite;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  sysreg_perm_top dut_i (
    .curEl(curEl), .regSel(regSel), .isWrite(isWrite), .haveEl3(haveEl3),
    .el3Enable(el3Enable), .trapStream(trapStream), .hostMode(hostMode),
    .el2Enabled(el2Enabled), .el1EnLow(el1EnLow), .el2EnLow(el2EnLow),
    .nvBits(nvBits), .sddUndefPrio(sddUndefPrio), .sddUndef(sddUndef),
    .outcome(outcome), .trapEl(trapEl), .trapClass(trapClass),
    .memOffset(memOffset), .xferWrite(xferWrite)
  );

  // Expected outcome, from the requirement text.
  logic [2:0]  expOut;
  logic [1:0]  expEl;
  logic [5:0]  expCls;
  string       tag;

  task automatic setExp(input logic [2:0] o, input logic [1:0] l, input logic [5:0] c,
                        input string t);
    expOut = o; expEl = l; expCls = c; tag = t;
  endtask

  task automatic model();
    logic blk;
    blk = haveEl3 && !el3Enable;
    if (curEl == 2'd0) setExp(3'd0, 2'd0, 6'h00, "R1");
    else if (curEl == 2'd1 && !regSel) begin
      if (nvBits[0]) setExp(3'd1, 2'd2, 6'h18, "R2");
      else           setExp(3'd0, 2'd0, 6'h00, "R2");
    end else if (curEl == 2'd1) begin
      if (blk && sddUndefPrio)                   setExp(3'd0, 2'd0, 6'h00, haveEl3 ? "R5" : "R10");
      else if (!el1EnLow)                        setExp(3'd1, 2'd1, 6'h1D, "R5");
      else if (el2Enabled && !hostMode && trapStream) setExp(3'd1, 2'd2, 6'h1D, "R5");
      else if (hostMode && !el2EnLow)            setExp(3'd1, 2'd2, 6'h1D, "R5");
      else if (blk)                              setExp(sddUndef ? 3'd0 : 3'd1, sddUndef ? 2'd0 : 2'd3,
                                                        sddUndef ? 6'h00 : 6'h1D, "R5");
      else if (nvBits == 3'b111)                 setExp(3'd4, 2'd0, 6'h00, "R6");
      else                                       setExp(3'd3, 2'd0, 6'h00, haveEl3 ? "R6" : "R10");
    end else if (curEl == 2'd2) begin
      if (blk && sddUndefPrio)                   setExp(3'd0, 2'd0, 6'h00, "R3");
      else if (!hostMode && trapStream)          setExp(3'd1, 2'd2, 6'h1D, "R3");
      else if (hostMode && !el2EnLow)            setExp(3'd1, 2'd2, 6'h1D, "R3");
      else if (blk)                              setExp(sddUndef ? 3'd0 : 3'd1, sddUndef ? 2'd0 : 2'd3,
                                                        sddUndef ? 6'h00 : 6'h1D, "R3");
      else if (regSel)                           setExp(hostMode ? 3'd2 : 3'd3, 2'd0, 6'h00, "R7");
      else                                       setExp(3'd2, 2'd0, 6'h00, haveEl3 ? "R3" : "R10");
    end else begin
      if (!haveEl3)        setExp(3'd0, 2'd0, 6'h00, "R10");
      else if (!el3Enable) setExp(3'd1, 2'd3, 6'h1D, "R4");
      else                 setExp(regSel ? 3'd3 : 3'd2, 2'd0, 6'h00, "R4");
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic checkAll();
    logic [11:0] expOff;
    logic        expW;
    model();
    expOff = (expOut == 3'd4) ? 12'h1F0 : 12'h000;
    expW   = (expOut >= 3'd2) && isWrite;
    check(outcome == expOut, tag, "outcome", outcome, expOut);
    check(trapEl == expEl && trapClass == expCls, (expOut == 3'd1) ? tag : "R9",
          "trap el/class", {trapEl, trapClass}, {expEl, expCls});
    check(memOffset == expOff, (expOut == 3'd4) ? "R6" : "R9", "memOffset", memOffset, expOff);
    check(xferWrite == expW, "R8", "xferWrite", xferWrite, expW);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG_CYCLES) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, WATCHDOG_CYCLES);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    {curEl, regSel, isWrite, haveEl3, el3Enable, trapStream, hostMode, el2Enabled,
     el1EnLow, el2EnLow, nvBits, sddUndefPrio, sddUndef} = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Reset-time state: all inputs zero means a level-0 read, undefined (R1)
    check(outcome == 3'd0 && xferWrite == 1'b0, "R1", "idle outcome", outcome, 0);

    // Exhaustive sweep over every input combination
    for (int v = 0; v < (1 << 16); v++) begin
      {curEl, regSel, isWrite, haveEl3, el3Enable, trapStream, hostMode, el2Enabled,
       el1EnLow, el2EnLow, nvBits, sddUndefPrio, sddUndef} = v[15:0];
      #1;
      checkAll();
    end

    // Direction independence: flip isWrite on a granted redirect case (R8)
    {curEl, regSel, haveEl3, el3Enable, trapStream, hostMode, el2Enabled,
     el1EnLow, el2EnLow, nvBits, sddUndefPrio, sddUndef} = {2'd1, 1'b1, 1'b1, 1'b1,
     1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 3'b111, 1'b0, 1'b0};
    isWrite = 1'b0; #1;
    check(outcome == 3'd4 && xferWrite == 1'b0, "R8", "redirect read", {outcome, xferWrite}, 8);
    isWrite = 1'b1; #1;
    check(outcome == 3'd4 && xferWrite == 1'b1, "R8", "redirect write", {outcome, xferWrite}, 9);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule